// File: doc/BRIEF.md
# Outbound PCI Window Decoder

This block sits on the CPU side of a host-to-PCI bridge and decides whether a CPU address is forwarded to PCI. The top 256 MiB of the 32-bit address space (top nibble 0xF) is cut into 32 windows of 8 MiB each. Window `i` starts at `0xF0000000 + i * 0x00800000`, so address bits [27:23] give the window index. Only windows 1 to 30 can ever be opened. Window 0 is kept for boot firmware and window 31 for the bridge's own registers.

Two control registers set the window map. The I/O control register carries a 2-bit forwarding mode in bits [8:7], and forwarding is on only when that field is exactly `01`. The window-enable register has one bit per window. Both are loaded through a single-cycle write port. A write changes the decode from the next clock cycle on. The hit flag and the window index are combinational from the presented address and the registered control state.

The forwarding mode is held as a two-state machine. `FWD_BLOCKED` is the reset state and closes every window. `FWD_PASS` lets the enable register decide. The machine has two transitions. `EV_OPEN` goes from `FWD_BLOCKED` to `FWD_PASS` when an I/O-control write carries mode `01`. `EV_CLOSE` goes from `FWD_PASS` to `FWD_BLOCKED` when an I/O-control write carries any other mode. Every other cycle holds the state.

Top module: `pciw_outwin_decoder`

## Requirements
- R1: After reset the mode machine is in `FWD_BLOCKED` and the enable register is zero, so `fwd_hit` is 0 for every address.
- R2: `win_idx` equals `cpu_addr[27:23]` when `cpu_addr[31:28]` is 0xF, and is 0 otherwise.
- R3: Forwarding is on only when the last I/O-control write had `reg_wr_data[8:7] == 2'b01`. The values 00, 10 and 11 close all windows. The other bits of that write have no effect on the decode.
- R4: For windows 1 to 30, `fwd_hit` is 1 exactly when `cpu_valid` is 1, the address is in the 0xF region, forwarding is on, and enable bit `win_idx` is set.
- R5: Enable bits 0 and 31 are ignored. Addresses in 0xF0000000–0xF07FFFFF and 0xFF800000–0xFFFFFFFF never hit.
- R6: An address whose top nibble is not 0xF never hits.
- R7: `fwd_hit` is 0 while `cpu_valid` is 0.
- R8: A register write changes `fwd_hit` only from the cycle after the write edge. Without a write, the decode of a steady address does not change.
- R9: `reg_wr_sel` = 0 selects the I/O control register and 1 selects the window-enable register. A write to one register leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe, one cycle per write |
| reg_wr_sel | input | 1 | 0 = I/O control register, 1 = window-enable register |
| reg_wr_data | input | 32 | Write data |
| cpu_addr | input | 32 | CPU address to decode |
| cpu_valid | input | 1 | Address qualifier |
| fwd_hit | output | 1 | Address falls in an open window |
| win_idx | output | 5 | Window index of the address, 0 outside the 0xF region |

## Verification
Every window index is decoded under each of the four mode values, combined with all-ones, alternating and empty enable masks. This separates the mode gate from the per-window enable. A walking single enable bit confirms that each enable bit opens only its own window, and that bits 0 and 31 open nothing. Probes at the first and last byte of each window check the index slice at both edges. Addresses outside the 0xF region and probes with `cpu_valid` low show that region and valid gate the hit independently of the control state. Probes taken before and after a write edge, and writes to one register followed by probes of the other's effect, show the one-cycle latency and that the two registers are independent.

// File: rtl/pciw_pkg.sv
package pciw_pkg;

    // Forwarding mode machine
    typedef enum logic {
        FWD_BLOCKED = 1'b0,
        FWD_PASS    = 1'b1
    } fwd_state_e;

    // Register write target
    typedef enum logic {
        SEL_IOCTRL = 1'b0,
        SEL_WINEN  = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/pciw_ctrl_regs.sv
module pciw_ctrl_regs
    import pciw_pkg::*;
#(
    parameter int unsigned REG_W    = 32,
    parameter int unsigned MODE_LSB = 7,
    parameter int unsigned MODE_W   = 2,
    parameter int unsigned MODE_ON  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic             fwd_on,
    output logic [REG_W-1:0] win_en
);

    // Bits 0 and REG_W-1 are reserved windows and can never open
    localparam logic [REG_W-1:0] KEEP_MASK =
        ~({{(REG_W-1){1'b0}}, 1'b1} | {1'b1, {(REG_W-1){1'b0}}});

    fwd_state_e       st_q, st_d;
    logic [REG_W-1:0] en_q;
    logic             ctrl_wr;
    logic             en_wr;
    logic             mode_match;

    assign ctrl_wr    = wr_en && (reg_sel_e'(wr_sel) == SEL_IOCTRL);
    assign en_wr      = wr_en && (reg_sel_e'(wr_sel) == SEL_WINEN);
    assign mode_match = (wr_data[MODE_LSB +: MODE_W] == MODE_W'(MODE_ON));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= FWD_BLOCKED;
        end else begin
            st_q <= st_d;
        end
    end

    // Transitions: EV_OPEN and EV_CLOSE
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FWD_BLOCKED: begin
                if (ctrl_wr && mode_match) begin
                    st_d = FWD_PASS;
                end
            end
            FWD_PASS: begin
                if (ctrl_wr && !mode_match) begin
                    st_d = FWD_BLOCKED;
                end
            end
            default: st_d = FWD_BLOCKED;
        endcase
    end

    // Outputs of the mode machine
    always_comb begin
        fwd_on = (st_q == FWD_PASS);
    end

    // Window-enable register, stored raw and masked on the way out
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_wr) begin
            en_q <= wr_data;
        end
    end

    assign win_en = en_q & KEEP_MASK;

endmodule

// File: rtl/pciw_addr_slice.sv
module pciw_addr_slice #(
    parameter int unsigned REGION_W   = 4,
    parameter int unsigned REGION_VAL = 15,
    parameter int unsigned IDX_W      = 5
) (
    input  logic [REGION_W+IDX_W-1:0] addr_tag,
    output logic                      in_region,
    output logic [IDX_W-1:0]          idx
);

    localparam int unsigned TAG_W = REGION_W + IDX_W;

    assign in_region = (addr_tag[TAG_W-1 -: REGION_W] == REGION_W'(REGION_VAL));
    assign idx       = in_region ? addr_tag[IDX_W-1:0] : '0;

endmodule

// File: rtl/pciw_win_gate.sv
module pciw_win_gate #(
    parameter int unsigned IDX_W = 5
) (
    input  logic                  fwd_on,
    input  logic [(1<<IDX_W)-1:0] win_en,
    input  logic                  in_region,
    input  logic                  valid,
    input  logic [IDX_W-1:0]      idx,
    output logic                  hit
);

    localparam int unsigned N_WIN = 1 << IDX_W;

    logic [N_WIN-1:0] open_vec;

    for (genvar g = 0; g < N_WIN; g++) begin : g_win
        assign open_vec[g] = fwd_on & win_en[g];
    end

    assign hit = valid & in_region & open_vec[idx];

endmodule

// File: rtl/pciw_outwin_decoder.sv
module pciw_outwin_decoder #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned REG_W      = 32,
    parameter int unsigned REGION_W   = 4,
    parameter int unsigned REGION_VAL = 15,
    parameter int unsigned MODE_LSB   = 7,
    parameter int unsigned MODE_W     = 2,
    parameter int unsigned MODE_ON    = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr_en,
    input  logic                     reg_wr_sel,
    input  logic [REG_W-1:0]         reg_wr_data,
    input  logic [ADDR_W-1:0]        cpu_addr,
    input  logic                     cpu_valid,
    output logic                     fwd_hit,
    output logic [$clog2(REG_W)-1:0] win_idx
);

    localparam int unsigned IDX_W = $clog2(REG_W);
    localparam int unsigned TAG_W = REGION_W + IDX_W;

    logic             fwd_on;
    logic [REG_W-1:0] win_en;
    logic             in_region;
    logic [IDX_W-1:0] idx;

    pciw_ctrl_regs #(
        .REG_W   (REG_W),
        .MODE_LSB(MODE_LSB),
        .MODE_W  (MODE_W),
        .MODE_ON (MODE_ON)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr_en),
        .wr_sel (reg_wr_sel),
        .wr_data(reg_wr_data),
        .fwd_on (fwd_on),
        .win_en (win_en)
    );

    pciw_addr_slice #(
        .REGION_W  (REGION_W),
        .REGION_VAL(REGION_VAL),
        .IDX_W     (IDX_W)
    ) u_slice (
        .addr_tag (cpu_addr[ADDR_W-1 -: TAG_W]),
        .in_region(in_region),
        .idx      (idx)
    );

    pciw_win_gate #(
        .IDX_W(IDX_W)
    ) u_gate (
        .fwd_on   (fwd_on),
        .win_en   (win_en),
        .in_region(in_region),
        .valid    (cpu_valid),
        .idx      (idx),
        .hit      (fwd_hit)
    );

    assign win_idx = idx;

endmodule

// File: rtl/pciw_outwin_checker.sv
module pciw_outwin_checker #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned REG_W      = 32,
    parameter int unsigned REGION_W   = 4,
    parameter int unsigned REGION_VAL = 15,
    parameter int unsigned MODE_LSB   = 7,
    parameter int unsigned MODE_W     = 2,
    parameter int unsigned MODE_ON    = 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     reg_wr_en,
    input logic                     reg_wr_sel,
    input logic [REG_W-1:0]         reg_wr_data,
    input logic [ADDR_W-1:0]        cpu_addr,
    input logic                     cpu_valid,
    input logic                     fwd_hit,
    input logic [$clog2(REG_W)-1:0] win_idx
);

    localparam int unsigned IDX_W = $clog2(REG_W);

    logic             region_ok;
    logic [IDX_W-1:0] addr_idx;

    assign region_ok = (cpu_addr[ADDR_W-1 -: REGION_W] == REGION_W'(REGION_VAL));
    assign addr_idx  = cpu_addr[ADDR_W-REGION_W-1 -: IDX_W];

    AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_valid |-> !fwd_hit);                                    // R7

    AST_OUTSIDE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !region_ok |-> (!fwd_hit && win_idx == '0));                 // R6

    AST_IDX_SLICE: assert property (@(posedge clk) disable iff (!rst_n)
        region_ok |-> (win_idx == addr_idx));                        // R2

    AST_RESERVED_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_idx == '0 || addr_idx == '1) |-> !fwd_hit);            // R5

    AST_MODE_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !reg_wr_sel &&
         reg_wr_data[MODE_LSB +: MODE_W] != MODE_W'(MODE_ON))
        |=> !fwd_hit);                                               // R3

    AST_EN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_wr_sel && reg_wr_data == '0) |=> !fwd_hit); // R4

    AST_MAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr_en && $stable(cpu_addr) && $stable(cpu_valid))
        |=> $stable(fwd_hit));                                       // R8

endmodule

bind pciw_outwin_decoder pciw_outwin_checker #(
    .ADDR_W    (ADDR_W),
    .REG_W     (REG_W),
    .REGION_W  (REGION_W),
    .REGION_VAL(REGION_VAL),
    .MODE_LSB  (MODE_LSB),
    .MODE_W    (MODE_W),
    .MODE_ON   (MODE_ON)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr_en  (reg_wr_en),
    .reg_wr_sel (reg_wr_sel),
    .reg_wr_data(reg_wr_data),
    .cpu_addr   (cpu_addr),
    .cpu_valid  (cpu_valid),
    .fwd_hit    (fwd_hit),
    .win_idx    (win_idx)
);

// File: tb/test_pciw_outwin_decoder.sv
module test_pciw_outwin_decoder;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_wr_sel = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] cpu_addr = '0;
    logic        cpu_valid = 1'b0;
    logic        fwd_hit;
    logic [4:0]  win_idx;

    int  n_vec  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    // Bench model of the control state
    logic [1:0]  m_mode = 2'b00;
    logic [31:0] m_en   = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pciw_outwin_decoder i_pciw_outwin_decoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr_en  (reg_wr_en),
        .reg_wr_sel (reg_wr_sel),
        .reg_wr_data(reg_wr_data),
        .cpu_addr   (cpu_addr),
        .cpu_valid  (cpu_valid),
        .fwd_hit    (fwd_hit),
        .win_idx    (win_idx)
    );

    function automatic logic exp_hit(logic [31:0] a, logic v);
        logic [4:0] i;
        i = a[27:23];
        return v && (a[31:28] == 4'hF) && (m_mode == 2'b01) &&
               (i != 5'd0) && (i != 5'd31) && m_en[i];
    endfunction

    function automatic logic [4:0] exp_idx(logic [31:0] a);
        return (a[31:28] == 4'hF) ? a[27:23] : 5'd0;
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h valid=%0b actual=%h expected=%h",
                     req, cpu_addr, cpu_valid, got, exp);
        end
    endtask

    task automatic write_reg(logic sel, logic [31:0] data);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_sel  = sel;
        reg_wr_data = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
        if (sel) m_en = data;
        else     m_mode = data[8:7];
    endtask

    task automatic probe(logic [31:0] a, logic v, string req);
        cpu_addr  = a;
        cpu_valid = v;
        #1;
        check(req, {31'd0, fwd_hit}, {31'd0, exp_hit(a, v)});
        check("R2", {27'd0, win_idx}, {27'd0, exp_idx(a)});
    endtask

    function automatic string tag_of(int idx, logic v);
        if (idx == 0 || idx == 31) return "R5";
        if (!v)                    return "R7";
        if (m_mode != 2'b01)       return "R3";
        return "R4";
    endfunction

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R8 watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [4];
        pats[0] = 32'hFFFF_FFFF;
        pats[1] = 32'h5555_5555;
        pats[2] = 32'hAAAA_AAAA;
        pats[3] = 32'h0000_0000;

        repeat (3) @(negedge clk);
        // R1: checks during and after reset
        probe(32'hF100_0000, 1'b1, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 32; i++) begin
            probe(32'hF000_0000 | (32'(i) << 23), 1'b1, "R1");
        end

        // Mode x enable pattern sweep over all windows, both window edges
        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 4; p++) begin
                // R3: other control bits set on odd patterns must not matter
                write_reg(1'b0, ((p % 2) ? 32'hFFFF_FE7F : 32'h0) | (32'(m) << 7));
                write_reg(1'b1, pats[p]);
                for (int i = 0; i < 32; i++) begin
                    for (int v = 0; v < 2; v++) begin
                        for (int o = 0; o < 2; o++) begin
                            probe(32'hF000_0000 | (32'(i) << 23) |
                                  (o ? 32'h007F_FFFF : 32'h0),
                                  v[0], tag_of(i, v[0]));
                        end
                    end
                end
            end
        end

        // R6: other regions with every window open
        write_reg(1'b0, 32'h0000_0080);
        write_reg(1'b1, 32'hFFFF_FFFF);
        for (int n = 0; n < 15; n++) begin
            for (int i = 0; i < 32; i += 5) begin
                probe((32'(n) << 28) | (32'(i) << 23) | 32'h0001_2340, 1'b1, "R6");
            end
        end

        // R4/R5: walking single enable bit
        for (int b = 0; b < 32; b++) begin
            write_reg(1'b1, 32'h1 << b);
            for (int i = 0; i < 32; i++) begin
                probe(32'hF000_0000 | (32'(i) << 23) | 32'h0000_0100, 1'b1,
                      (b == 0 || b == 31) ? "R5" : "R4");
            end
        end

        // R9: enable write keeps the mode; control write keeps the enables
        write_reg(1'b1, 32'h0000_0002);
        probe(32'hF080_0000, 1'b1, "R9");
        probe(32'hF100_0000, 1'b1, "R9");
        write_reg(1'b0, 32'h0000_0000);
        probe(32'hF080_0000, 1'b1, "R9");
        write_reg(1'b1, 32'hFFFF_FFFF);
        probe(32'hF280_0000, 1'b1, "R9");
        write_reg(1'b0, 32'h0000_0080);
        probe(32'hF080_0000, 1'b1, "R9");
        probe(32'hF280_0000, 1'b1, "R9");

        // R8: write takes effect only after the edge
        @(negedge clk);
        cpu_addr    = 32'hF280_0000;
        cpu_valid   = 1'b1;
        reg_wr_en   = 1'b1;
        reg_wr_sel  = 1'b1;
        reg_wr_data = 32'h0;
        #1;
        check("R8", {31'd0, fwd_hit}, 32'd1);
        @(negedge clk);
        reg_wr_en = 1'b0;
        m_en      = 32'h0;
        #1;
        check("R8", {31'd0, fwd_hit}, 32'd0);

        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_sel  = 1'b1;
        reg_wr_data = 32'hFFFF_FFFF;
        #1;
        check("R8", {31'd0, fwd_hit}, 32'd0);
        @(negedge clk);
        reg_wr_en = 1'b0;
        m_en      = 32'hFFFF_FFFF;
        #1;
        check("R8", {31'd0, fwd_hit}, 32'd1);
        repeat (4) @(negedge clk);
        #1;
        check("R8", {31'd0, fwd_hit}, 32'd1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule